// File: doc/BRIEF.md
# Uneven-split Karatsuba multiplier over GF(2^193)

This block multiplies two elements of the binary field GF(2^M), with M = 193 by default, in polynomial basis, and returns their product reduced by the trinomial x^M + x^TAP + 1 (TAP = 15 by default). Each operand is cut at bit SPLIT (128 by default) into a wide low part and a narrow high part of M - SPLIT bits (65 by default). Three carry-less sub-products are formed: low by low, high by high, and the cross product of the XOR-folded parts. The cross product is cancelled against both outer products to give the middle term. The three terms are placed at offsets 0, SPLIT and 2·SPLIT to build a 2M-1 bit raw product, which a reduction network then folds down to M bits.

The wide sub-products come from a recursive Karatsuba core that halves the width until it reaches BASE bits, where a schoolbook carry-less multiplier takes over. The narrow, odd-width high product is not given its own three-way split. It reuses one Karatsuba core of width M-SPLIT-1, adds two gated copies of the other operand's lower bits for the top bits, and a single AND for the top-by-top term. The whole datapath is combinational. A two-state output controller registers the result and raises a valid flag one clock after an accepted operand pair.

Output controller states: ST_EMPTY (no result held valid) and ST_FULL (result register valid). Transitions: EMPTY→FULL when in_valid is high, FULL→FULL when in_valid is high again, FULL→EMPTY and EMPTY→EMPTY when in_valid is low. Reset forces ST_EMPTY.

Top module: `gf_hybrid_kara_mul`

## Requirements
- R1: For any operands a and b of M bits, out_prod equals a·b mod (x^M + x^TAP + 1), where bit i of each bus is the coefficient of x^i. The result always has degree below M.
- R2: out_valid is high in exactly the cycles that follow a rising clock edge at which in_valid was high, and is low otherwise.
- R3: While in_valid is low, out_prod keeps its last value.
- R4: While rst_n is low, out_valid and out_prod are 0. The controller is in ST_EMPTY.
- R5: If either operand is zero, the registered product is zero.
- R6: If operand a equals 1 (only bit 0 set), the registered product equals operand b.
- R7: Operands whose set bits lie only in the high part, including the top bit M-1 of both operands, give the correctly reduced product. For example, x^(M-1)·x^(M-1) = x^(2M-2) folded by the trinomial.
- R8: All-ones operands give the correctly reduced product.
- R9: Operand pairs presented on consecutive cycles each produce their own product, one cycle later and in order, with no gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair valid this cycle |
| in_a | input | M | First operand, bit i is coefficient of x^i |
| in_b | input | M | Second operand |
| out_valid | output | 1 | out_prod holds the product of the pair accepted one cycle earlier |
| out_prod | output | M | Reduced product |

## Verification
The bench builds two copies of the block. The first uses the default field (M=193, SPLIT=128, TAP=15, BASE=16) and receives corner operands, high-part-only operands and random pairs. The second is a small copy with M=7, SPLIT=4, TAP=1 and BASE=2. Its operand space of 16384 pairs is small enough to stream through completely, back to back. That sweep reaches every branch of the recursion at a depth of two, every top-bit combination of the odd-width high core, and every fold of the reduction network.

// File: rtl/gf_kara_pkg.sv
package gf_kara_pkg;

    // Output controller states
    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } out_state_e;

    // Default field: x^193 + x^15 + 1, split 128 + 65
    localparam int unsigned DEF_M     = 193;
    localparam int unsigned DEF_SPLIT = 128;
    localparam int unsigned DEF_TAP   = 15;
    localparam int unsigned DEF_BASE  = 16;

endpackage

// File: rtl/gf_kara_core.sv
// Recursive carry-less Karatsuba multiplier, W must be BASE * 2^k.
module gf_kara_core #(
    parameter int unsigned W    = 128,
    parameter int unsigned BASE = 16
) (
    input  logic [W-1:0]   op_a,
    input  logic [W-1:0]   op_b,
    output logic [2*W-2:0] prod
);
    localparam int unsigned PW = 2 * W - 1;

    generate
        if (W <= BASE) begin : g_school
            always_comb begin
                prod = '0;
                for (int i = 0; i < W; i++) begin
                    prod = prod ^ ((PW'(op_a) << i) & {PW{op_b[i]}});
                end
            end
        end else begin : g_split
            localparam int unsigned H  = W / 2;
            localparam int unsigned HP = 2 * H - 1;

            logic [HP-1:0] z_lo, z_hi, z_x;
            logic [HP-1:0] z_mid;

            gf_kara_core #(.W(H), .BASE(BASE)) u_lo (
                .op_a(op_a[H-1:0]), .op_b(op_b[H-1:0]), .prod(z_lo));
            gf_kara_core #(.W(H), .BASE(BASE)) u_hi (
                .op_a(op_a[W-1:H]), .op_b(op_b[W-1:H]), .prod(z_hi));
            gf_kara_core #(.W(H), .BASE(BASE)) u_x (
                .op_a(op_a[H-1:0] ^ op_a[W-1:H]),
                .op_b(op_b[H-1:0] ^ op_b[W-1:H]),
                .prod(z_x));

            always_comb begin
                z_mid = z_x ^ z_lo ^ z_hi;
                prod  = PW'(z_lo) ^ (PW'(z_mid) << H) ^ (PW'(z_hi) << W);
            end
        end
    endgenerate
endmodule

// File: rtl/gf_odd_mul.sv
// Carry-less product of (C+1)-bit operands: C-bit Karatsuba core,
// two C x 1 gated terms and one AND for the top bits.
module gf_odd_mul #(
    parameter int unsigned W    = 65,
    parameter int unsigned BASE = 16
) (
    input  logic [W-1:0]   op_a,
    input  logic [W-1:0]   op_b,
    output logic [2*W-2:0] prod
);
    localparam int unsigned C  = W - 1;
    localparam int unsigned PW = 2 * W - 1;

    logic [2*C-2:0] core_p;
    logic [C-1:0]   term_a, term_b;
    logic           top_p;

    gf_kara_core #(.W(C), .BASE(BASE)) u_core (
        .op_a(op_a[C-1:0]), .op_b(op_b[C-1:0]), .prod(core_p));

    always_comb begin
        term_a = op_a[C] ? op_b[C-1:0] : '0;
        term_b = op_b[C] ? op_a[C-1:0] : '0;
        top_p  = op_a[C] & op_b[C];
        prod   = PW'(core_p)
               ^ (PW'(term_a) << C)
               ^ (PW'(term_b) << C)
               ^ (PW'(top_p) << (2 * C));
    end
endmodule

// File: rtl/gf_trinomial_reduce.sv
// Folds a (2M-1)-bit raw product modulo x^M + x^TAP + 1.
module gf_trinomial_reduce #(
    parameter int unsigned M   = 193,
    parameter int unsigned TAP = 15
) (
    input  logic [2*M-2:0] wide,
    output logic [M-1:0]   red
);
    localparam int unsigned PW = 2 * M - 1;

    logic [PW-1:0] work;

    always_comb begin
        work = wide;
        for (int i = PW - 1; i >= int'(M); i--) begin
            if (work[i]) begin
                work[i]           = 1'b0;
                work[i - M]       = ~work[i - M];
                work[i - M + TAP] = ~work[i - M + TAP];
            end
        end
        red = work[M-1:0];
    end
endmodule

// File: rtl/gf_hybrid_kara_mul.sv
module gf_hybrid_kara_mul
    import gf_kara_pkg::*;
#(
    parameter int unsigned M     = DEF_M,
    parameter int unsigned SPLIT = DEF_SPLIT,
    parameter int unsigned TAP   = DEF_TAP,
    parameter int unsigned BASE  = DEF_BASE
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [M-1:0] in_a,
    input  logic [M-1:0] in_b,
    output logic         out_valid,
    output logic [M-1:0] out_prod
);
    localparam int unsigned HW  = M - SPLIT;       // high part width
    localparam int unsigned LPW = 2 * SPLIT - 1;   // low / cross product width
    localparam int unsigned HPW = 2 * HW - 1;      // high product width
    localparam int unsigned PW  = 2 * M - 1;       // raw product width

    // operand parts
    logic [SPLIT-1:0] a_lo, b_lo, a_fold, b_fold;
    logic [HW-1:0]    a_hi, b_hi;

    always_comb begin
        a_lo   = in_a[SPLIT-1:0];
        b_lo   = in_b[SPLIT-1:0];
        a_hi   = in_a[M-1:SPLIT];
        b_hi   = in_b[M-1:SPLIT];
        a_fold = a_lo ^ SPLIT'(a_hi);
        b_fold = b_lo ^ SPLIT'(b_hi);
    end

    // three sub-products
    logic [LPW-1:0] p_ll, p_x, p_mid;
    logic [HPW-1:0] p_hh;

    gf_kara_core #(.W(SPLIT), .BASE(BASE)) u_ll (
        .op_a(a_lo), .op_b(b_lo), .prod(p_ll));
    gf_kara_core #(.W(SPLIT), .BASE(BASE)) u_cross (
        .op_a(a_fold), .op_b(b_fold), .prod(p_x));
    gf_odd_mul #(.W(HW), .BASE(BASE)) u_hh (
        .op_a(a_hi), .op_b(b_hi), .prod(p_hh));

    // recombination
    logic [PW-1:0] raw;

    always_comb begin
        p_mid = p_x ^ p_ll ^ LPW'(p_hh);
        raw   = PW'(p_ll) ^ (PW'(p_mid) << SPLIT) ^ (PW'(p_hh) << (2 * SPLIT));
    end

    logic [M-1:0] reduced;

    gf_trinomial_reduce #(.M(M), .TAP(TAP)) u_red (
        .wide(raw), .red(reduced));

    // output controller
    out_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: state_d = in_valid ? ST_FULL : ST_EMPTY;
            ST_FULL:  state_d = in_valid ? ST_FULL : ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    logic [M-1:0] prod_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        prod_q <= '0;
        else if (in_valid) prod_q <= reduced;
    end

    always_comb begin
        out_valid = (state_q == ST_FULL);
        out_prod  = prod_q;
    end
endmodule

// File: rtl/gf_hybrid_kara_mul_sva.sv
module gf_hybrid_kara_mul_sva #(
    parameter int unsigned M = 193
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [M-1:0] in_a,
    input logic [M-1:0] in_b,
    input logic         out_valid,
    input logic [M-1:0] out_prod
);
    always_comb begin
        if (!rst_n) begin
            AST_RESET_CLEAR: assert (!out_valid && out_prod == '0); // R4
        end
    end

    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_prod)); // R3
    AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_a == '0 || in_b == '0)) |=> (out_prod == '0)); // R5
    AST_ONE_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_a == M'(1)) |=> (out_prod == $past(in_b))); // R6
endmodule

bind gf_hybrid_kara_mul gf_hybrid_kara_mul_sva #(.M(M)) u_sva (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_prod(out_prod));

// File: tb/gf_hybrid_kara_mul_bench.sv
module gf_hybrid_kara_mul_bench;
    localparam int CLK_PERIOD = 10;
    localparam int BM = 193;
    localparam int SM = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic          v_big = 1'b0, v_small = 1'b0;
    logic [BM-1:0] a_big = '0, b_big = '0;
    logic [SM-1:0] a_small = '0, b_small = '0;
    logic          ov_big, ov_small;
    logic [BM-1:0] p_big;
    logic [SM-1:0] p_small;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    gf_hybrid_kara_mul u_gf_hybrid_kara_mul (
        .clk(clk), .rst_n(rst_n), .in_valid(v_big), .in_a(a_big), .in_b(b_big),
        .out_valid(ov_big), .out_prod(p_big));

    gf_hybrid_kara_mul #(.M(SM), .SPLIT(4), .TAP(1), .BASE(2)) u_small (
        .clk(clk), .rst_n(rst_n), .in_valid(v_small), .in_a(a_small), .in_b(b_small),
        .out_valid(ov_small), .out_prod(p_small));

    // shift-and-add reference modulo x^m + x^tap + 1
    function automatic logic [192:0] ref_mul(input logic [192:0] a, input logic [192:0] b,
                                             input int m, input int tap);
        logic [193:0] r = '0;
        for (int i = m - 1; i >= 0; i--) begin
            r = r << 1;
            if (r[m]) begin
                r[m]   = 1'b0;
                r[0]   = ~r[0];
                r[tap] = ~r[tap];
            end
            if (b[i]) r = r ^ {1'b0, a};
        end
        return r[192:0];
    endfunction

    task automatic chk(input string req, input logic [192:0] act, input logic [192:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_big(input string req, input logic [BM-1:0] a, input logic [BM-1:0] b);
        @(negedge clk);
        a_big = a; b_big = b; v_big = 1'b1;
        @(negedge clk);
        v_big = 1'b0;
        chk({req, " valid"}, 193'(ov_big), 193'(1));
        chk(req, 193'(p_big), ref_mul(193'(a), 193'(b), BM, 15));
    endtask

    function automatic logic [BM-1:0] rnd193();
        return {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [BM-1:0] held;
        logic [BM-1:0] sa [3];
        logic [BM-1:0] sb [3];
        logic [SM-1:0] pa, pb;

        // R4: reset state
        repeat (3) @(negedge clk);
        chk("R4 valid", 193'(ov_big), '0);
        chk("R4 prod", 193'(p_big), '0);
        chk("R4 small", 193'({ov_small, p_small}), '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 idle after reset", 193'(ov_big), '0);

        // R5: zero operands
        run_big("R5 zero a", '0, rnd193());
        run_big("R5 zero b", rnd193(), '0);
        // R6: identity
        run_big("R6 one", BM'(1), rnd193());
        run_big("R6 one times one", BM'(1), BM'(1));
        // R8: all ones
        run_big("R8 all ones", '1, '1);
        run_big("R8 all ones by one", '1, BM'(1));
        // R7: high part only
        run_big("R7 top bits", BM'(1) << (BM - 1), BM'(1) << (BM - 1));
        run_big("R7 high ones", {65'h1_FFFF_FFFF_FFFF_FFFF, 128'h0}, {65'h1_0000_0000_0000_0001, 128'h0});
        run_big("R7 high by low", {65'h1_2345_6789_ABCD_EF01, 128'h0}, rnd193());

        // R3: hold while idle
        held = p_big;
        a_big = rnd193(); b_big = rnd193();
        @(negedge clk);
        chk("R3 hold", 193'(p_big), 193'(held));
        chk("R2 drop", 193'(ov_big), '0);
        @(negedge clk);
        chk("R3 hold second", 193'(p_big), 193'(held));

        // R1: random pairs
        for (int k = 0; k < 200; k++) run_big("R1 random", rnd193(), rnd193());

        // R9: back-to-back streaming
        for (int k = 0; k < 3; k++) begin
            sa[k] = rnd193(); sb[k] = rnd193();
        end
        @(negedge clk);
        a_big = sa[0]; b_big = sb[0]; v_big = 1'b1;
        for (int k = 1; k < 3; k++) begin
            @(negedge clk);
            chk("R9 stream valid", 193'(ov_big), 193'(1));
            chk("R9 stream", 193'(p_big), ref_mul(sa[k-1], sb[k-1], BM, 15));
            a_big = sa[k]; b_big = sb[k];
        end
        @(negedge clk);
        v_big = 1'b0;
        chk("R9 stream last", 193'(p_big), ref_mul(sa[2], sb[2], BM, 15));

        // R1 R9: exhaustive sweep of the small field, streamed
        pa = '0; pb = '0;
        for (int i = 0; i < 128; i++) begin
            for (int j = 0; j < 128; j++) begin
                @(negedge clk);
                if (i != 0 || j != 0) begin
                    chk("R1 small sweep", 193'(p_small), ref_mul(193'(pa), 193'(pb), SM, 1));
                end
                a_small = SM'(i); b_small = SM'(j); v_small = 1'b1;
                pa = SM'(i); pb = SM'(j);
            end
        end
        @(negedge clk);
        v_small = 1'b0;
        chk("R1 small sweep last", 193'(p_small), ref_mul(193'(pa), 193'(pb), SM, 1));
        chk("R9 small valid", 193'(ov_small), 193'(1));
        @(negedge clk);
        chk("R2 small drop", 193'(ov_small), '0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule